// File: doc/BRIEF.md
# Synthetic Video Frame Stream Generator

This block produces a synthetic video frame as a stream of byte beats for a camera-serial-style transmitter. It is meant to feed the packet builder that forms the packets. Each beat is one of three kinds: a frame-start marker, a frame-end marker or a byte of a long line packet. Line packets carry a programmable data type and virtual channel. Line bytes show either a set of vertical color bars or one fixed color. All frame timing comes from static configuration inputs and is counted in line slots. A line slot is a window of `cfg_line_period` clocks that is stretched when its beats need more clocks.

A frame is `cfg_total_lines` slots long. The frame-start marker opens slot 0. The back porch slots are blank, and the active slots follow them. The front porch slots are blank too. The frame-end marker opens the slot whose index is back porch + active + front porch. The remaining slots up to the total are inter-frame blanking. Output uses a valid/ready handshake, and `out_ready` may stall any beat. The line slot timer keeps counting while a beat is stalled.

Top module: `vid_patgen`

## Requirements
- R1: The frame-start beat (`out_kind`=0) is the first beat of each frame and has `out_data`=0. The frame-end beat (`out_kind`=1) also has `out_data`=0. Both carry `cfg_vchan`. With `out_ready` held high and every slot's beats fitting in `cfg_line_period`, successive frame-start beats are `cfg_total_lines`*`cfg_line_period` clocks apart.
- R2: The frame-end beat is accepted (`cfg_vbp`+`cfg_active_lines`+`cfg_vfp`)*`cfg_line_period` clocks after the frame-start beat, under the same conditions as in R1. A frame carries exactly `cfg_active_lines` line packets, all between the two markers.
- R3: Each line packet is `cfg_line_bytes` beats of `out_kind`=2. `out_sol` is set on the first of these beats only and `out_eol` on the last only. Each beat carries `cfg_dtype` and `cfg_vchan`.
- R4: In bar mode, the byte at line position x equals C[(x / `cfg_bar_bytes`) mod N], where N = 1 << `cfg_bar_sel` (1, 2, 4 or 8). The table is C[i] = 8'hFF - 8'h24*i.
- R5: With `cfg_fixed_mode`=1, every line byte equals `cfg_fixed_color`.
- R6: When a slot needs more beats than `cfg_line_period`, the line is sent whole and the slot stretches. With ready high, the slot length is max(period, beats in the slot).
- R7: Setting `cfg_enable` starts a frame from slot 0. Clearing it during a frame lets that frame finish through its last blanking slot, and then no further beat appears.
- R8: While `out_valid` is high and `out_ready` is low, the beat stays valid with its kind, data and flags unchanged.
- R9: After reset, `out_valid` is low until `cfg_enable` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_enable | input | 1 | Run request; sampled at frame boundaries |
| cfg_fixed_mode | input | 1 | 1 = fixed color, 0 = color bars |
| cfg_fixed_color | input | 8 | Byte value used in fixed mode |
| cfg_bar_sel | input | 2 | Bar count is 1 << value |
| cfg_line_bytes | input | LINE_W | Bytes per line packet (at least 1) |
| cfg_bar_bytes | input | LINE_W | Bytes per color bar (at least 1) |
| cfg_dtype | input | 6 | Data type placed on line beats |
| cfg_vchan | input | 2 | Virtual channel placed on all beats |
| cfg_active_lines | input | LCNT_W | Active lines per frame |
| cfg_total_lines | input | LCNT_W | Line slots per frame |
| cfg_vbp | input | LCNT_W | Blank slots after frame start |
| cfg_vfp | input | LCNT_W | Blank slots before frame end |
| cfg_line_period | input | PER_W | Clocks per line slot |
| out_ready | input | 1 | Sink accepts the beat |
| out_valid | output | 1 | Beat present |
| out_kind | output | 2 | 0 frame start, 1 frame end, 2 line byte |
| out_data | output | 8 | Line byte, 0 on markers |
| out_sol | output | 1 | First byte of line packet |
| out_eol | output | 1 | Last byte of line packet |
| out_dtype | output | 6 | Data type of the beat |
| out_vchan | output | 2 | Virtual channel of the beat |

## Verification
The bench builds the block with its default widths: 16-bit byte and period counts and 12-bit line counts. It programs small frames so that several whole frames fit in a short run. One setup has 8 slots of 16 clocks, so the frame-start and frame-end spacing can be timed exactly. A second uses a 4-clock period with 20-byte lines and 8 bars of 2 bytes, which exercises slot stretching, the wrap through all eight table entries and a back porch of zero. A single-bar setup and a fixed-color setup run under pseudo-random backpressure.

// File: rtl/vpg_pkg.sv
package vpg_pkg;
  typedef enum logic [1:0] {
    EV_FS   = 2'd0,
    EV_FE   = 2'd1,
    EV_LINE = 2'd2
  } ev_kind_t;

  // color of bar i: descending ramp
  function automatic logic [7:0] bar_color(input logic [2:0] idx);
    return 8'hFF - (8'(idx) * 8'h24);
  endfunction

  // wrap mask for 1,2,4,8 bars
  function automatic logic [2:0] bar_mask(input logic [1:0] sel);
    return 3'((4'd1 << sel) - 4'd1);
  endfunction
endpackage

// File: rtl/vpg_slot_timer.sv
module vpg_slot_timer #(
  parameter int LCNT_W = 12,
  parameter int PER_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [LCNT_W-1:0] total_lines,
  input  logic [PER_W-1:0]  line_period,
  input  logic              slot_end,
  output logic              running,
  output logic              advance,
  output logic [LCNT_W-1:0] line_idx,
  output logic [LCNT_W-1:0] nxt_line,
  output logic              period_met
);
  logic [PER_W-1:0]  timer;
  logic [LCNT_W-1:0] last_slot;
  logic              start;
  logic              frame_last;

  assign last_slot  = (total_lines == '0) ? '0 : total_lines - 1'b1;
  assign frame_last = (line_idx >= last_slot);
  assign start      = !running && enable;
  assign advance    = start || slot_end;
  assign nxt_line   = (start || frame_last) ? '0 : line_idx + 1'b1;
  assign period_met = ((PER_W+1)'(timer) + (PER_W+1)'(1)) >= (PER_W+1)'(line_period);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running  <= 1'b0;
      line_idx <= '0;
      timer    <= '0;
    end else if (start) begin
      running  <= 1'b1;
      line_idx <= '0;
      timer    <= '0;
    end else if (slot_end) begin
      timer    <= '0;
      line_idx <= nxt_line;
      if (frame_last) running <= enable;
    end else if (running && timer != '1) begin
      timer <= timer + 1'b1;
    end
  end
endmodule

// File: rtl/vpg_bar_walker.sv
module vpg_bar_walker
  import vpg_pkg::*;
#(
  parameter int LINE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              step,
  input  logic [LINE_W-1:0] line_bytes,
  input  logic [LINE_W-1:0] bar_bytes,
  input  logic [1:0]        bar_sel,
  input  logic              fixed_mode,
  input  logic [7:0]        fixed_color,
  output logic [7:0]        data,
  output logic              first,
  output logic              last
);
  logic [LINE_W-1:0] xpos;
  logic [LINE_W-1:0] bcnt;
  logic [2:0]        bar;
  logic              bar_done;

  assign bar_done = ((LINE_W+1)'(bcnt) + (LINE_W+1)'(1)) >= (LINE_W+1)'(bar_bytes);
  assign first    = (xpos == '0);
  assign last     = ((LINE_W+1)'(xpos) + (LINE_W+1)'(1)) >= (LINE_W+1)'(line_bytes);
  assign data     = fixed_mode ? fixed_color : bar_color(bar);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xpos <= '0;
      bcnt <= '0;
      bar  <= '0;
    end else if (restart) begin
      xpos <= '0;
      bcnt <= '0;
      bar  <= '0;
    end else if (step) begin
      xpos <= xpos + 1'b1;
      if (bar_done) begin
        bcnt <= '0;
        bar  <= (bar + 3'd1) & bar_mask(bar_sel);
      end else begin
        bcnt <= bcnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/vid_patgen.sv
module vid_patgen
  import vpg_pkg::*;
#(
  parameter int LINE_W = 16,
  parameter int LCNT_W = 12,
  parameter int PER_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_enable,
  input  logic              cfg_fixed_mode,
  input  logic [7:0]        cfg_fixed_color,
  input  logic [1:0]        cfg_bar_sel,
  input  logic [LINE_W-1:0] cfg_line_bytes,
  input  logic [LINE_W-1:0] cfg_bar_bytes,
  input  logic [5:0]        cfg_dtype,
  input  logic [1:0]        cfg_vchan,
  input  logic [LCNT_W-1:0] cfg_active_lines,
  input  logic [LCNT_W-1:0] cfg_total_lines,
  input  logic [LCNT_W-1:0] cfg_vbp,
  input  logic [LCNT_W-1:0] cfg_vfp,
  input  logic [PER_W-1:0]  cfg_line_period,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [1:0]        out_kind,
  output logic [7:0]        out_data,
  output logic              out_sol,
  output logic              out_eol,
  output logic [5:0]        out_dtype,
  output logic [1:0]        out_vchan
);
  localparam int SUM_W = LCNT_W + 2;

  typedef enum logic [1:0] {PH_FS, PH_FE, PH_LINE, PH_WAIT} phase_t;

  function automatic logic in_window(input logic [LCNT_W-1:0] l,
                                     input logic [SUM_W-1:0] lo,
                                     input logic [SUM_W-1:0] hi);
    return (SUM_W'(l) >= lo) && (SUM_W'(l) < hi);
  endfunction

  function automatic phase_t entry_phase(input logic [LCNT_W-1:0] l,
                                         input logic [SUM_W-1:0] fe_l,
                                         input logic [SUM_W-1:0] lo,
                                         input logic [SUM_W-1:0] hi);
    if (l == '0)                return PH_FS;
    else if (SUM_W'(l) == fe_l) return PH_FE;
    else if (in_window(l, lo, hi)) return PH_LINE;
    else                        return PH_WAIT;
  endfunction

  logic [SUM_W-1:0]  act_lo, act_hi, fe_line;
  logic              w_running, w_advance, w_period_met, w_slot_end, w_fire;
  logic              w_last_beat, w_line_active;
  logic [LCNT_W-1:0] w_line, w_nxt_line;
  logic [7:0]        pix_data;
  logic              pix_first, pix_last;
  phase_t            ph;

  assign act_lo  = SUM_W'(cfg_vbp);
  assign act_hi  = SUM_W'(cfg_vbp) + SUM_W'(cfg_active_lines);
  assign fe_line = act_hi + SUM_W'(cfg_vfp);

  assign w_line_active = in_window(w_line, act_lo, act_hi);
  assign w_fire        = out_valid && out_ready;

  always_comb begin
    unique case (ph)
      PH_FS:   w_last_beat = w_fire && !w_line_active;
      PH_FE:   w_last_beat = w_fire;
      PH_LINE: w_last_beat = w_fire && pix_last;
      default: w_last_beat = 1'b0;
    endcase
  end

  assign w_slot_end = w_running && w_period_met && (ph == PH_WAIT || w_last_beat);

  vpg_slot_timer #(.LCNT_W(LCNT_W), .PER_W(PER_W)) i_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (cfg_enable),
    .total_lines (cfg_total_lines),
    .line_period (cfg_line_period),
    .slot_end    (w_slot_end),
    .running     (w_running),
    .advance     (w_advance),
    .line_idx    (w_line),
    .nxt_line    (w_nxt_line),
    .period_met  (w_period_met)
  );

  vpg_bar_walker #(.LINE_W(LINE_W)) i_walker (
    .clk         (clk),
    .rst_n       (rst_n),
    .restart     (w_advance),
    .step        (w_fire && ph == PH_LINE),
    .line_bytes  (cfg_line_bytes),
    .bar_bytes   (cfg_bar_bytes),
    .bar_sel     (cfg_bar_sel),
    .fixed_mode  (cfg_fixed_mode),
    .fixed_color (cfg_fixed_color),
    .data        (pix_data),
    .first       (pix_first),
    .last        (pix_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= PH_WAIT;
    end else if (w_advance) begin
      ph <= entry_phase(w_nxt_line, fe_line, act_lo, act_hi);
    end else if (w_fire) begin
      unique case (ph)
        PH_FS:   ph <= w_line_active ? PH_LINE : PH_WAIT;
        PH_FE:   ph <= PH_WAIT;
        PH_LINE: if (pix_last) ph <= PH_WAIT;
        default: ph <= ph;
      endcase
    end
  end

  assign out_valid = w_running && (ph != PH_WAIT);
  assign out_kind  = (ph == PH_FS) ? EV_FS : (ph == PH_FE) ? EV_FE : EV_LINE;
  assign out_data  = (ph == PH_LINE) ? pix_data : 8'h00;
  assign out_sol   = (ph == PH_LINE) && pix_first;
  assign out_eol   = (ph == PH_LINE) && pix_last;
  assign out_dtype = cfg_dtype;
  assign out_vchan = cfg_vchan;
endmodule

// File: rtl/vid_patgen_chk.sv
module vid_patgen_chk
  import vpg_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       out_valid,
  input logic       out_ready,
  input logic [1:0] out_kind,
  input logic [7:0] out_data,
  input logic       out_sol,
  input logic       out_eol,
  input logic       cfg_fixed_mode,
  input logic [7:0] cfg_fixed_color,
  input logic       w_running
);
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_kind) && $stable(out_data)
                               && $stable(out_sol) && $stable(out_eol))
    else $error("R8 stalled beat changed");

  p_flags_kind_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (out_sol || out_eol) |-> out_kind == EV_LINE)
    else $error("R3 packet flag on marker beat");

  p_marker_data_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_kind != EV_LINE |-> out_data == 8'h00)
    else $error("R1 marker carries data");

  p_fixed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_kind == EV_LINE && cfg_fixed_mode |-> out_data == cfg_fixed_color)
    else $error("R5 fixed byte mismatch");

  p_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(w_running) |-> out_valid && out_kind == EV_FS)
    else $error("R7 frame did not open with frame start");
endmodule

bind vid_patgen vid_patgen_chk i_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .out_valid       (out_valid),
  .out_ready       (out_ready),
  .out_kind        (out_kind),
  .out_data        (out_data),
  .out_sol         (out_sol),
  .out_eol         (out_eol),
  .cfg_fixed_mode  (cfg_fixed_mode),
  .cfg_fixed_color (cfg_fixed_color),
  .w_running       (w_running)
);

// File: tb/test_vid_patgen.sv
module test_vid_patgen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_enable = 1'b0;
  logic        cfg_fixed_mode = 1'b0;
  logic [7:0]  cfg_fixed_color = 8'h00;
  logic [1:0]  cfg_bar_sel = 2'd0;
  logic [15:0] cfg_line_bytes = 16'd1;
  logic [15:0] cfg_bar_bytes = 16'd1;
  logic [5:0]  cfg_dtype = 6'h00;
  logic [1:0]  cfg_vchan = 2'd0;
  logic [11:0] cfg_active_lines = 12'd1;
  logic [11:0] cfg_total_lines = 12'd2;
  logic [11:0] cfg_vbp = 12'd0;
  logic [11:0] cfg_vfp = 12'd0;
  logic [15:0] cfg_line_period = 16'd1;
  logic        out_ready = 1'b1;
  logic        out_valid;
  logic [1:0]  out_kind;
  logic [7:0]  out_data;
  logic        out_sol, out_eol;
  logic [5:0]  out_dtype;
  logic [1:0]  out_vchan;

  always #5 clk = ~clk;

  vid_patgen i_vid_patgen (.*);

  typedef struct packed {
    logic [1:0] kind;
    logic [7:0] data;
    logic       sol;
    logic       eol;
  } beat_t;

  beat_t exp_q[$];
  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int beats = 0;
  int fs_count = 0;
  int last_fs = 0, prev_fs = 0, last_fe = 0;
  logic bp_mode = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  function automatic logic [7:0] ref_color(input int i);
    case (i)
      0: return 8'hFF; 1: return 8'hDB; 2: return 8'hB7; 3: return 8'h93;
      4: return 8'h6F; 5: return 8'h4B; 6: return 8'h27; default: return 8'h03;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // driver: expected beats of one frame
  task automatic push_frame();
    int nb;
    nb = 1 << cfg_bar_sel;
    exp_q.push_back('{kind: 2'd0, data: 8'h00, sol: 1'b0, eol: 1'b0});
    for (int l = 0; l < int'(cfg_active_lines); l++) begin
      for (int x = 0; x < int'(cfg_line_bytes); x++) begin
        beat_t b;
        b.kind = 2'd2;
        b.data = cfg_fixed_mode ? cfg_fixed_color
                                : ref_color((x / int'(cfg_bar_bytes)) % nb);
        b.sol  = (x == 0);
        b.eol  = (x == int'(cfg_line_bytes) - 1);
        exp_q.push_back(b);
      end
    end
    exp_q.push_back('{kind: 2'd1, data: 8'h00, sol: 1'b0, eol: 1'b0});
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  end

  always @(posedge clk) begin
    #1 out_ready <= bp_mode ? lfsr[3] : 1'b1;
  end

  // monitor
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      beats++;
      if (exp_q.size() == 0) begin
        check(1'b0, "R7 unexpected beat", int'(out_kind), -1);
      end else begin
        beat_t e;
        e = exp_q.pop_front();
        check(out_kind == e.kind, "R2 beat kind", int'(out_kind), int'(e.kind));
        check(out_data == e.data, "R4 beat data", int'(out_data), int'(e.data));
        check(out_sol == e.sol && out_eol == e.eol, "R3 sol/eol",
              int'({out_sol, out_eol}), int'({e.sol, e.eol}));
        check(out_vchan == cfg_vchan, "R1 vchan", int'(out_vchan), int'(cfg_vchan));
        if (out_kind == 2'd2)
          check(out_dtype == cfg_dtype, "R3 dtype", int'(out_dtype), int'(cfg_dtype));
      end
      if (out_kind == 2'd0) begin
        prev_fs = last_fs;
        last_fs = cyc;
        fs_count++;
      end
      if (out_kind == 2'd1) last_fe = cyc;
    end
  end

  task automatic run_frames(input int k);
    int base, b0, t;
    base = fs_count;
    for (int i = 0; i < k; i++) push_frame();
    @(negedge clk);
    cfg_enable = 1'b1;
    wait (fs_count == base + k);
    @(negedge clk);
    cfg_enable = 1'b0;
    t = 0;
    while (exp_q.size() != 0 && t < 20000) begin
      @(negedge clk);
      t++;
    end
    check(exp_q.size() == 0, "R7 frame completes after disable", exp_q.size(), 0);
    b0 = beats;
    repeat (300) @(negedge clk);
    check(beats == b0, "R7 no beat after stop", beats - b0, 0);
    check(out_valid == 1'b0, "R7 idle valid", int'(out_valid), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R9 valid in reset", int'(out_valid), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(out_valid == 1'b0, "R9 valid before enable", int'(out_valid), 0);

    // setup A: 8 slots of 16 clocks, 4 bars of 3 bytes
    cfg_bar_sel = 2'd2; cfg_line_bytes = 16'd12; cfg_bar_bytes = 16'd3;
    cfg_dtype = 6'h2A; cfg_vchan = 2'd1;
    cfg_vbp = 12'd1; cfg_active_lines = 12'd3; cfg_vfp = 12'd1;
    cfg_total_lines = 12'd8; cfg_line_period = 16'd16;
    run_frames(2);
    check(last_fs - prev_fs == 128, "R1 frame spacing", last_fs - prev_fs, 128);
    check(last_fe - last_fs == 80, "R2 frame end offset", last_fe - last_fs, 80);

    // setup B: fixed color with backpressure (R5, R8)
    cfg_fixed_mode = 1'b1; cfg_fixed_color = 8'h5C; cfg_vchan = 2'd3;
    bp_mode = 1'b1;
    run_frames(1);
    bp_mode = 1'b0;
    cfg_fixed_mode = 1'b0;

    // setup C: period shorter than the line (R6), 8 bars wrap (R4)
    cfg_bar_sel = 2'd3; cfg_line_bytes = 16'd20; cfg_bar_bytes = 16'd2;
    cfg_vbp = 12'd0; cfg_active_lines = 12'd2; cfg_vfp = 12'd0;
    cfg_total_lines = 12'd4; cfg_line_period = 16'd4; cfg_dtype = 6'h1E;
    run_frames(2);
    check(last_fs - prev_fs == 49, "R6 stretched frame", last_fs - prev_fs, 49);
    check(last_fe - last_fs == 41, "R6 stretched frame end", last_fe - last_fs, 41);

    // setup D: single bar under backpressure (R4, R8)
    cfg_bar_sel = 2'd0; cfg_line_bytes = 16'd7; cfg_bar_bytes = 16'd5;
    cfg_vbp = 12'd2; cfg_active_lines = 12'd2; cfg_vfp = 12'd2;
    cfg_total_lines = 12'd9; cfg_line_period = 16'd10;
    bp_mode = 1'b1;
    run_frames(1);
    bp_mode = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule